// File: doc/BRIEF.md
# LPC Host SYNC Phase Monitor

This block sits beside the host-side cycle sequencer of a Low Pin Count bus interface. Once the sequencer has finished its turnaround for a memory, I/O or DMA cycle, it pulses `sync_start` and presents the cycle kind. From the next clock on, the monitor samples the 4-bit bus nibble on every edge and sorts it. The categories are: ready, short wait, long wait, ready-with-more (DMA only), error, floating (no response) and reserved. It returns exactly one single-cycle verdict to the sequencer: done, done-more, error or abort. An abort is only a request. The sequencer performs the actual framing abort.

The monitor has two states. `ST_IDLE` ignores the bus. `ST_SYNC` classifies the bus every clock. There are four named transitions:

- START (`ST_IDLE` to `ST_SYNC`) happens on `sync_start`. It latches whether the cycle is DMA and clears the no-response counter.
- HOLD (`ST_SYNC` to `ST_SYNC`) happens on a short or long wait code, or on a floating nibble before the limit. A wait code clears the counter. A floating nibble advances it.
- FINISH (`ST_SYNC` to `ST_IDLE`) happens on ready, ready-more or error, with the matching pulse.
- ABORT (`ST_SYNC` to `ST_IDLE`) happens on a reserved or illegal code, or on the fourth consecutive floating nibble, with an abort pulse.

The block can also be the wait-state source for bus-master cycles. When enabled it drives the long-wait code.

Top module: `lpc_sync_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `done_more`, `err` and `abort` are low. The monitor rests in idle.
- R2: In the SYNC phase, nibble 4'b0000 gives a single `done` pulse in the cycle after the sampling edge. The monitor then returns to idle.
- R3: Nibble 4'b1001 gives `done_more` when the cycle kind is DMA (`cycle_kind` 2'b10). For memory (2'b00), I/O (2'b01) and the unused kind 2'b11 it gives `abort`.
- R4: Nibble 4'b1010 gives a single `err` pulse and ends the cycle.
- R5: Nibbles 4'b0101 (short wait) and 4'b0110 (long wait) produce no output and keep the monitor in SYNC for any number of clocks, including runs far longer than eight.
- R6: Nibble 4'b1111 means no response. Four consecutive such samples give `abort` on the fourth. Any wait code in between restarts the count.
- R7: Every nibble outside {0000, 0101, 0110, 1001, 1010, 1111} gives `abort` on the first sample.
- R8: At most one of the four verdict outputs is high in any cycle. In idle, the bus nibble has no effect on the outputs until the next `sync_start`. `sync_start` during SYNC is ignored.
- R9: `lad_oe` follows `wait_src_en`. While it is high, `lad_drive` carries 4'b0110 and never 4'b0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_start | input | 1 | Begins SYNC monitoring (honoured in idle) |
| cycle_kind | input | 2 | 00 memory, 01 I/O, 10 DMA, 11 treated as non-DMA |
| lad_in | input | 4 | Sampled bus nibble |
| wait_src_en | input | 1 | Request to act as wait-state source |
| done | output | 1 | Pulse: ready received |
| done_more | output | 1 | Pulse: ready-more received on a DMA cycle |
| err | output | 1 | Pulse: error code received |
| abort | output | 1 | Pulse: abort request to the sequencer |
| lad_drive | output | 4 | Nibble driven when acting as wait source |
| lad_oe | output | 1 | Output enable for `lad_drive` |

## Verification
A state register stuck in SYNC would show as verdict pulses after a finished cycle, or as a reaction to idle-time bus noise, in the very next clock. A register stuck in idle would show as a missing pulse one clock after the deciding nibble. A lost DMA flag swaps `done_more` for `abort` on the 1001 sample. A wrong no-response count moves or suppresses the abort, so it is visible within four clocks of a floating run. Long wait runs with floating gaps between them expose a counter that is not cleared by a wait code.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    typedef enum logic [1:0] {
        KIND_MEM = 2'b00,
        KIND_IO  = 2'b01,
        KIND_DMA = 2'b10,
        KIND_RSV = 2'b11
    } cyc_kind_e;

    typedef enum logic [2:0] {
        CLS_READY,
        CLS_MORE,
        CLS_WAIT,
        CLS_ERR,
        CLS_FLOAT,
        CLS_BAD
    } sync_cls_e;

    typedef enum logic {
        ST_IDLE,
        ST_SYNC
    } mon_state_e;

    typedef struct packed {
        logic done;
        logic more;
        logic err;
        logic abort;
    } mon_evt_t;

    localparam int          NIB_W      = 4;
    localparam logic [3:0]  CODE_READY = 4'b0000;
    localparam logic [3:0]  CODE_SHORT = 4'b0101;
    localparam logic [3:0]  CODE_LONG  = 4'b0110;
    localparam logic [3:0]  CODE_MORE  = 4'b1001;
    localparam logic [3:0]  CODE_ERR   = 4'b1010;
    localparam logic [3:0]  CODE_FLOAT = 4'b1111;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
    import lpc_sync_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    input  logic             is_dma,
    output sync_cls_e        cls
);
    always_comb begin
        unique case (nib)
            CODE_READY: cls = CLS_READY;
            CODE_SHORT,
            CODE_LONG:  cls = CLS_WAIT;
            CODE_MORE:  cls = is_dma ? CLS_MORE : CLS_BAD;
            CODE_ERR:   cls = CLS_ERR;
            CODE_FLOAT: cls = CLS_FLOAT;
            default:    cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/lpc_sync_float_cnt.sv
module lpc_sync_float_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpc_sync_monitor.sv
module lpc_sync_monitor
    import lpc_sync_pkg::*;
#(
    parameter int FLOAT_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_start,
    input  logic [1:0] cycle_kind,
    input  logic [3:0] lad_in,
    input  logic       wait_src_en,
    output logic       done,
    output logic       done_more,
    output logic       err,
    output logic       abort,
    output logic [3:0] lad_drive,
    output logic       lad_oe
);
    mon_state_e state_q, state_d;
    mon_evt_t   evt_q, evt_d;
    sync_cls_e  cls;
    logic       dma_q;
    logic       cnt_clr, cnt_bump, float_last;
    logic       in_sync;

    assign in_sync = (state_q == ST_SYNC);

    lpc_sync_decode dec_i (
        .nib    (lad_in),
        .is_dma (dma_q),
        .cls    (cls)
    );

    lpc_sync_float_cnt #(.LIMIT(FLOAT_LIMIT)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clr),
        .bump  (cnt_bump),
        .last  (float_last)
    );

    // next state and next verdict
    always_comb begin
        state_d  = state_q;
        evt_d    = '0;
        cnt_clr  = 1'b0;
        cnt_bump = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_start) begin
                    state_d = ST_SYNC;
                    cnt_clr = 1'b1;
                end
            end
            ST_SYNC: begin
                unique case (cls)
                    CLS_READY: begin
                        evt_d.done = 1'b1;
                        state_d    = ST_IDLE;
                    end
                    CLS_MORE: begin
                        evt_d.more = 1'b1;
                        state_d    = ST_IDLE;
                    end
                    CLS_ERR: begin
                        evt_d.err = 1'b1;
                        state_d   = ST_IDLE;
                    end
                    CLS_WAIT: begin
                        cnt_clr = 1'b1;
                    end
                    CLS_FLOAT: begin
                        if (float_last) begin
                            evt_d.abort = 1'b1;
                            state_d     = ST_IDLE;
                        end else begin
                            cnt_bump = 1'b1;
                        end
                    end
                    CLS_BAD: begin
                        evt_d.abort = 1'b1;
                        state_d     = ST_IDLE;
                    end
                    default: begin
                        evt_d.abort = 1'b1;
                        state_d     = ST_IDLE;
                    end
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and cycle-kind latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dma_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && sync_start) begin
                dma_q <= (cycle_kind == KIND_DMA);
            end
        end
    end

    // registered verdict pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign done      = evt_q.done;
    assign done_more = evt_q.more;
    assign err       = evt_q.err;
    assign abort     = evt_q.abort;

    // wait-state source: long wait only
    assign lad_oe    = wait_src_en;
    assign lad_drive = wait_src_en ? CODE_LONG : 4'b0000;

endmodule

// File: rtl/lpc_sync_monitor_chk.sv
module lpc_sync_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_sync,
    input logic       dma_q,
    input logic [3:0] lad_in,
    input logic       done,
    input logic       done_more,
    input logic       err,
    input logic       abort,
    input logic [3:0] lad_drive,
    input logic       lad_oe
);
    logic reserved_nib;
    assign reserved_nib = !(lad_in inside {4'b0000, 4'b0101, 4'b0110, 4'b1001, 4'b1010, 4'b1111});

    // R8
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, done_more, err, abort}));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> !(done || done_more || err || abort));

    // R2
    ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && lad_in == 4'b0000) |=> done);

    // R3
    more_nondma_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !dma_q && lad_in == 4'b1001) |=> abort);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && (lad_in == 4'b0101 || lad_in == 4'b0110))
            |=> (in_sync && !(done || done_more || err || abort)));

    // R7
    reserved_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && reserved_nib) |=> abort);

    // R9
    long_wait_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lad_oe |-> (lad_drive == 4'b0110));
endmodule

bind lpc_sync_monitor lpc_sync_monitor_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_sync   (in_sync),
    .dma_q     (dma_q),
    .lad_in    (lad_in),
    .done      (done),
    .done_more (done_more),
    .err       (err),
    .abort     (abort),
    .lad_drive (lad_drive),
    .lad_oe    (lad_oe)
);

// File: tb/lpc_sync_monitor_tb_top.sv
module lpc_sync_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_start;
    logic [1:0] cycle_kind;
    logic [3:0] lad_in;
    logic       wait_src_en;
    logic       done, done_more, err, abort, lad_oe;
    logic [3:0] lad_drive;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // bench reference state
    bit      m_active = 1'b0;
    bit      m_dma    = 1'b0;
    int      m_cnt    = 0;
    logic [3:0] exp_v;
    string   exp_tag;

    always #2 clk = ~clk;

    lpc_sync_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .sync_start(sync_start), .cycle_kind(cycle_kind),
        .lad_in(lad_in), .wait_src_en(wait_src_en), .done(done), .done_more(done_more),
        .err(err), .abort(abort), .lad_drive(lad_drive), .lad_oe(lad_oe)
    );

    function automatic bit is_known(input logic [3:0] n);
        return n inside {4'b0000, 4'b0101, 4'b0110, 4'b1001, 4'b1010, 4'b1111};
    endfunction

    // expected {done, more, err, abort} for one edge; updates the reference state
    function automatic logic [3:0] predict(input bit st, input logic [1:0] k,
                                          input logic [3:0] n, output string tag);
        logic [3:0] v = 4'b0000;
        tag = "R8";
        if (!m_active) begin
            if (st) begin
                m_active = 1'b1;
                m_dma    = (k == 2'b10);
                m_cnt    = 0;
            end
        end else if (n == 4'b0000) begin
            v = 4'b1000; m_active = 1'b0; tag = "R2";
        end else if (n == 4'b1001) begin
            v = m_dma ? 4'b0100 : 4'b0001; m_active = 1'b0; tag = "R3";
        end else if (n == 4'b1010) begin
            v = 4'b0010; m_active = 1'b0; tag = "R4";
        end else if (n == 4'b0101 || n == 4'b0110) begin
            m_cnt = 0; tag = "R5";
        end else if (n == 4'b1111) begin
            tag = "R6";
            if (m_cnt == 3) begin v = 4'b0001; m_active = 1'b0; end
            else m_cnt++;
        end else begin
            v = 4'b0001; m_active = 1'b0; tag = "R7";
        end
        return v;
    endfunction

    task automatic step(input bit st, input logic [1:0] k, input logic [3:0] n, input bit ws);
        logic [3:0] act;
        sync_start  = st;
        cycle_kind  = k;
        lad_in      = n;
        wait_src_en = ws;
        exp_v = predict(st, k, n, exp_tag);
        @(posedge clk);
        @(negedge clk);
        act = {done, done_more, err, abort};
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s: verdict actual=%b expected=%b (lad=%b)", exp_tag, act, exp_v, n);
        end
        n_checks++;
        if (lad_oe !== ws || (ws && lad_drive !== 4'b0110)) begin
            n_errors++;
            $display("FAIL R9: oe/drive actual=%b/%b expected=%b/0110", lad_oe, lad_drive, ws);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [3:0] pick [8];
        void'($urandom(32'd7411));
        rst_n = 1'b0; sync_start = 1'b0; cycle_kind = 2'b00; lad_in = 4'b0000; wait_src_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        n_checks++;
        if ({done, done_more, err, abort} !== 4'b0000) begin
            n_errors++;
            $display("FAIL R1: actual=%b expected=0000", {done, done_more, err, abort});
        end
        rst_n = 1'b1;
        // R1: idle after reset, noise ignored
        step(0, 2'b00, 4'b0000, 0);
        step(0, 2'b00, 4'b1010, 0);

        // R2: ready on memory cycle
        step(1, 2'b00, 4'b1111, 0); step(0, 2'b00, 4'b0000, 0);
        // R8: LAD after verdict ignored
        step(0, 2'b00, 4'b0011, 0); step(0, 2'b00, 4'b1001, 0);
        // R3: ready-more on DMA, then on I/O
        step(1, 2'b10, 4'b0000, 0); step(0, 2'b10, 4'b1001, 0);
        step(1, 2'b01, 4'b0000, 0); step(0, 2'b01, 4'b1001, 0);
        step(1, 2'b11, 4'b0000, 0); step(0, 2'b11, 4'b1001, 0);
        // R4: error
        step(1, 2'b10, 4'b0000, 1); step(0, 2'b10, 4'b1010, 1);
        // R5: twenty short waits, sync_start during SYNC ignored (R8), then ready
        step(1, 2'b00, 4'b0000, 0);
        for (int i = 0; i < 20; i++) step(i == 5, 2'b10, 4'b0101, 1);
        step(0, 2'b00, 4'b0110, 0); step(0, 2'b00, 4'b0000, 0);
        // R6: three floats, wait resets count, three floats, ready
        step(1, 2'b00, 4'b0000, 0);
        for (int i = 0; i < 3; i++) step(0, 2'b00, 4'b1111, 0);
        step(0, 2'b00, 4'b0110, 0);
        for (int i = 0; i < 3; i++) step(0, 2'b00, 4'b1111, 0);
        step(0, 2'b00, 4'b0000, 0);
        // R6: four floats abort
        step(1, 2'b01, 4'b0000, 0);
        for (int i = 0; i < 4; i++) step(0, 2'b01, 4'b1111, 0);
        // R7: each reserved code aborts at once
        for (int c = 0; c < 16; c++) begin
            if (!is_known(4'(c))) begin
                step(1, 2'b10, 4'b0000, 0);
                step(0, 2'b10, 4'(c), 0);
            end
        end

        // constrained random mix
        pick[0] = 4'b0000; pick[1] = 4'b0101; pick[2] = 4'b0110; pick[3] = 4'b1001;
        pick[4] = 4'b1010; pick[5] = 4'b1111; pick[6] = 4'b1111; pick[7] = 4'b0110;
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] n;
            bit st;
            n  = ($urandom % 10 == 0) ? 4'($urandom) : pick[$urandom % 8];
            st = ($urandom % 3 == 0);
            step(st, 2'($urandom), n, 1'($urandom));
        end
        finish_run();
    end
endmodule